// File: doc/BRIEF.md
# Converter Cycle Sequencer with Serial Result Readout

This block is the digital side of a sampling converter. It runs a cycle of three states in a fixed order: `ST_CONVERT`, then `ST_SLEEP`, then `ST_OUTPUT`. In `ST_CONVERT` it asks the converter core for a result with a one-cycle start pulse, then waits for the core's done pulse. On the done pulse it captures the result word into a static shift register and moves to `ST_SLEEP`. It stays there, with the low-power flag raised and the word frozen, for as long as the chip-select pin stays high.

When chip select goes low, the sequencer moves to `ST_OUTPUT` and presents the word on the serial data pin, most significant bit first. The host samples each bit on a rising serial-clock edge, and the block puts the next bit on the pin after the following falling edge. There are two ways out of `ST_OUTPUT`, and both lead back to `ST_CONVERT` with a new start pulse. The normal exit is the rising edge that samples the last bit. The abort exit is chip select going high before that edge.

The transitions are: reset→`ST_CONVERT` (start pulse), `ST_CONVERT`→`ST_SLEEP` on done, `ST_SLEEP`→`ST_OUTPUT` on chip select low, `ST_OUTPUT`→`ST_CONVERT` on the last rising edge (complete) or on chip select high (abort). The chip-select and serial-clock pins are asynchronous to the system clock. A configurable synchronizer brings them in, and an edge detector follows it.

Top module: `adc_cycle_ctrl`

## Requirements
- R1: After reset is released, the block is in `ST_CONVERT` and pulses `conv_start` once. `sleep_flag` and `sdo_oe` are low.
- R2: A `conv_done` pulse in `ST_CONVERT` captures `conv_data` and moves the block to `ST_SLEEP`. `sleep_flag` goes high.
- R3: In `ST_SLEEP` with `cs_n` high, the block stays asleep for any length of time. A `conv_done` pulse there does not change the stored word.
- R4: `cs_n` low in `ST_SLEEP` moves the block to `ST_OUTPUT`. `sleep_flag` falls, `sdo_oe` rises, and `sdo` shows bit DATA_W-1 of the word.
- R5: Each falling `sck` edge in `ST_OUTPUT` advances `sdo` to the next lower bit. A host that samples on DATA_W rising edges receives the whole word, MSB first.
- R6: The DATA_W-th rising `sck` edge returns the block to `ST_CONVERT` and pulses `conv_start`. `sdo_oe` drops.
- R7: `cs_n` high in `ST_OUTPUT` before the last bit abandons the readout. The block returns to `ST_CONVERT` and pulses `conv_start`. The next result is then read out intact.
- R8: `sdo_oe` is high only in `ST_OUTPUT` while synchronized `cs_n` is low. It is low in `ST_SLEEP` and `ST_CONVERT`.
- R9: `sck` edges outside `ST_OUTPUT` have no effect on the stored word.
- R10: `conv_start` is high for exactly one clock, and only on entry to `ST_CONVERT`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| conv_done | input | 1 | One-cycle completion pulse from the converter core |
| conv_data | input | DATA_W | Result word from the converter core, valid with `conv_done` |
| conv_start | output | 1 | One-cycle request to begin a conversion |
| cs_n | input | 1 | Chip select pin, active low, asynchronous |
| sck | input | 1 | Serial clock pin, idles low, asynchronous |
| sdo | output | 1 | Serial data, MSB first |
| sdo_oe | output | 1 | Output enable for `sdo`; low means high impedance |
| sleep_flag | output | 1 | High only in `ST_SLEEP` |

## Verification
The bench builds the block with DATA_W = 24 and SYNC_STAGES = 2. At these values, full 24-bit readouts of words with a set MSB, a lone LSB, all ones and all zeros all finish in a few thousand clocks. This covers the normal exit and both end bits of the word. The two-stage synchronizer gives a short, known delay from pin to state, so the bench can abort a readout after five bits. It can also toggle `sck` while the block sleeps and then confirm at the data pin that the stored word did not change.

// File: rtl/adc_cyc_pkg.sv
package adc_cyc_pkg;
    typedef enum logic [1:0] {
        ST_CONVERT = 2'd0,
        ST_SLEEP   = 2'd1,
        ST_OUTPUT  = 2'd2
    } cyc_state_e;
endpackage

// File: rtl/adc_pin_sync.sv
module adc_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_pin,
    input  logic sck_pin,
    output logic cs_hi,
    output logic sck_rise,
    output logic sck_fall
);
    logic [STAGES-1:0] cs_pipe;
    logic [STAGES-1:0] sck_pipe;
    logic              sck_prev;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cs_pipe  <= '1;
                    sck_pipe <= '0;
                end else begin
                    cs_pipe  <= cs_n_pin;
                    sck_pipe <= sck_pin;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cs_pipe  <= '1;
                    sck_pipe <= '0;
                end else begin
                    cs_pipe  <= {cs_pipe[STAGES-2:0], cs_n_pin};
                    sck_pipe <= {sck_pipe[STAGES-2:0], sck_pin};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_prev <= 1'b0;
        else        sck_prev <= sck_pipe[STAGES-1];
    end

    assign cs_hi    = cs_pipe[STAGES-1];
    assign sck_rise =  sck_pipe[STAGES-1] & ~sck_prev;
    assign sck_fall = ~sck_pipe[STAGES-1] &  sck_prev;
endmodule

// File: rtl/adc_result_shreg.sv
module adc_result_shreg #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         shift_en,
    output logic [W-1:0] word
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        word <= '0;
        else if (load)     word <= load_data;
        else if (shift_en) word <= {word[W-2:0], 1'b0};
    end
endmodule

// File: rtl/adc_cycle_fsm.sv
module adc_cycle_fsm
    import adc_cyc_pkg::*;
#(
    parameter int W = 24
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       conv_done,
    input  logic       cs_hi,
    input  logic       sck_rise,
    input  logic       sck_fall,
    output cyc_state_e state,
    output logic       load,
    output logic       shift_en,
    output logic       conv_start
);
    localparam int CNT_W = (W > 1) ? $clog2(W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

    cyc_state_e       nxt;
    logic [CNT_W-1:0] bit_cnt;
    logic             fresh_q;
    logic             enter_conv;

    always_comb begin
        nxt        = state;
        enter_conv = 1'b0;
        unique case (state)
            ST_CONVERT: if (conv_done) nxt = ST_SLEEP;
            ST_SLEEP:   if (!cs_hi)    nxt = ST_OUTPUT;
            ST_OUTPUT: begin
                if (cs_hi || (sck_rise && bit_cnt == LAST)) begin
                    nxt        = ST_CONVERT;
                    enter_conv = 1'b1;
                end
            end
            default:    nxt = ST_CONVERT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_CONVERT;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt    <= '0;
            fresh_q    <= 1'b1;
            conv_start <= 1'b0;
        end else begin
            fresh_q    <= 1'b0;
            conv_start <= fresh_q | enter_conv;
            if (state != ST_OUTPUT)
                bit_cnt <= '0;
            else if (sck_rise)
                bit_cnt <= bit_cnt + 1'b1;
        end
    end

    assign load     = (state == ST_CONVERT) && conv_done;
    assign shift_en = (state == ST_OUTPUT) && !cs_hi && sck_fall;
endmodule

// File: rtl/adc_cycle_ctrl.sv
module adc_cycle_ctrl
    import adc_cyc_pkg::*;
#(
    parameter int DATA_W      = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    output logic              conv_start,
    input  logic              cs_n,
    input  logic              sck,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              sleep_flag
);
    cyc_state_e        state;
    logic              cs_hi, sck_rise, sck_fall;
    logic              load, shift_en;
    logic [DATA_W-1:0] word_q;

    adc_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .cs_n_pin(cs_n), .sck_pin(sck),
        .cs_hi(cs_hi), .sck_rise(sck_rise), .sck_fall(sck_fall)
    );

    adc_cycle_fsm #(.W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .cs_hi(cs_hi),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .state(state),
        .load(load), .shift_en(shift_en), .conv_start(conv_start)
    );

    adc_result_shreg #(.W(DATA_W)) u_shreg (
        .clk(clk), .rst_n(rst_n), .load(load), .load_data(conv_data),
        .shift_en(shift_en), .word(word_q)
    );

    assign sdo        = (state == ST_OUTPUT) ? word_q[DATA_W-1] : 1'b0;
    assign sdo_oe     = (state == ST_OUTPUT) && !cs_hi;
    assign sleep_flag = (state == ST_SLEEP);
endmodule

// File: rtl/adc_cycle_ctrl_chk.sv
module adc_cycle_ctrl_chk
    import adc_cyc_pkg::*;
#(
    parameter int W = 24
) (
    input logic         clk,
    input logic         rst_n,
    input logic         conv_done,
    input logic         conv_start,
    input logic         sleep_flag,
    input logic         sdo_oe,
    input cyc_state_e   state,
    input logic [W-1:0] word
);
    AST_SLEEP_NO_OE: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_flag |-> !sdo_oe); // R8
    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start); // R10
    AST_START_IN_CONVERT: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> state == ST_CONVERT); // R6
    AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_flag && $past(sleep_flag)) |-> word == $past(word)); // R3
    AST_SLEEP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sleep_flag) |-> state == ST_OUTPUT); // R4
    AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_flag) |-> $past(conv_done)); // R2
endmodule

bind adc_cycle_ctrl adc_cycle_ctrl_chk #(.W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_start(conv_start),
    .sleep_flag(sleep_flag), .sdo_oe(sdo_oe), .state(state), .word(word_q)
);

// File: tb/adc_cycle_ctrl_tb.sv
module adc_cycle_ctrl_tb;
    localparam int W = 24;
    localparam int NV = 6;
    localparam logic [W-1:0] VEC [NV] = '{24'hA5C3F0, 24'h000001, 24'h800000,
                                          24'hFFFFFF, 24'h000000, 24'h5A5A5A};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic conv_done = 1'b0;
    logic [W-1:0] conv_data = '0;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic conv_start, sdo, sdo_oe, sleep_flag;
    int   n_tests = 0;
    int   n_fail = 0;
    int   starts = 0;

    always #4 clk = ~clk;

    adc_cycle_ctrl #(.DATA_W(W), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_data(conv_data),
        .conv_start(conv_start), .cs_n(cs_n), .sck(sck), .sdo(sdo),
        .sdo_oe(sdo_oe), .sleep_flag(sleep_flag)
    );

    always @(negedge clk) if (conv_start) starts++;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_up;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    task automatic deliver(input logic [W-1:0] d);
        conv_data = d;
        conv_done = 1'b1;
        wait_clk(1);
        conv_done = 1'b0;
        conv_data = '0;
        wait_clk(1);
    endtask

    task automatic sck_pulse;
        sck = 1'b1; wait_clk(5);
        sck = 1'b0; wait_clk(5);
    endtask

    // read nbits, sampling sdo before each rising edge; leaves cs_n low
    task automatic read_bits(input int nbits, output logic [W-1:0] got,
                             output bit oe_ok);
        got = '0;
        oe_ok = 1'b1;
        cs_n = 1'b0;
        wait_clk(6);
        for (int i = 0; i < nbits; i++) begin
            if (!sdo_oe) oe_ok = 1'b0;
            got = {got[W-2:0], sdo};
            sck_pulse();
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        finish_up();
    end

    initial begin
        logic [W-1:0] got;
        bit oe_ok;
        int s0;

        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(3);
        // R1: reset state
        chk(starts == 1, "R1 start pulse after reset", starts, 1);
        chk(!sleep_flag && !sdo_oe, "R1 flags low after reset",
            {sleep_flag, sdo_oe}, 0);

        // table walk: R2, R4, R5, R6
        for (int v = 0; v < NV; v++) begin
            s0 = starts;
            deliver(VEC[v]);
            chk(sleep_flag == 1'b1, "R2 sleep after done", sleep_flag, 1);
            chk(sdo_oe == 1'b0, "R8 oe low while asleep", sdo_oe, 0);
            cs_n = 1'b0;
            wait_clk(6);
            chk(!sleep_flag && sdo_oe && sdo == VEC[v][W-1], "R4 output entry",
                {sleep_flag, sdo_oe, sdo}, {2'b01, VEC[v][W-1]});
            cs_n = 1'b1;   // abort is not intended here; restore before read
            wait_clk(6);
            // the short pulse above aborted: re-run conversion for a clean read
            deliver(VEC[v]);
            read_bits(W, got, oe_ok);
            chk(got == VEC[v] && oe_ok, "R5 full word MSB first", got, VEC[v]);
            chk(!sdo_oe && starts == s0 + 2, "R6 return to convert with start",
                {sdo_oe, 8'(starts - s0)}, {1'b0, 8'd2});
            cs_n = 1'b1;
            wait_clk(6);
        end

        // R3, R9: long sleep, stray done pulse and sck activity, word held
        deliver(24'h3C96E1);
        wait_clk(400);
        conv_data = 24'h111111;
        conv_done = 1'b1;
        wait_clk(1);
        conv_done = 1'b0;
        for (int k = 0; k < 5; k++) sck_pulse();
        chk(sleep_flag == 1'b1, "R3 still asleep with cs_n high", sleep_flag, 1);
        chk(sdo_oe == 1'b0, "R8 oe low in sleep", sdo_oe, 0);
        read_bits(W, got, oe_ok);
        chk(got == 24'h3C96E1, "R3 R9 word unchanged by done and sck in sleep",
            got, 24'h3C96E1);
        cs_n = 1'b1;
        wait_clk(6);

        // R7: abort after 5 bits
        s0 = starts;
        deliver(24'hC0FFEE);
        read_bits(5, got, oe_ok);
        chk(got[4:0] == 5'b11000, "R7 partial bits before abort", got[4:0], 5'b11000);
        cs_n = 1'b1;
        wait_clk(6);
        chk(!sdo_oe && !sleep_flag && starts == s0 + 1, "R7 abort to convert",
            {sdo_oe, sleep_flag, 8'(starts - s0)}, {2'b00, 8'd1});
        deliver(24'h123456);
        read_bits(W, got, oe_ok);
        chk(got == 24'h123456, "R7 next result intact after abort", got, 24'h123456);
        cs_n = 1'b1;
        wait_clk(6);

        // R10 / R8: no start pulse and no oe while converting
        s0 = starts;
        wait_clk(50);
        chk(starts == s0 && !sdo_oe, "R10 no extra start in convert",
            {sdo_oe, 8'(starts - s0)}, 0);

        finish_up();
    end
endmodule